// File: doc/BRIEF.md
# Parallel Addressable-LED Waveform Encoder

This block turns colour values into the one-wire return-to-zero waveform used by chains of smart RGB LEDs. It drives up to sixteen chains at once, with one output lane per chain. Every data bit is sent as three equal time slots. The first slot is high on every lane. The second slot carries each lane's own bit. The third slot is low. A logic one is therefore two slots high and one low, and a logic zero is one slot high and two low. With 400 ns slots this gives 0.8/0.4 µs for a one and 0.4/0.8 µs for a zero.

A transfer begins with a start pulse and the number of LEDs per chain. The block sends a short run of all-zero slots, then one 72-slot group per LED position, then a closing run of all-zero slots, and then returns to idle. Colours arrive over a valid/ready port, one word per LED position, with a 24-bit red-green-blue value for every lane in that word. Internally the block holds the LED being sent and one prefetched word. When a word is missing at the moment its LED begins, that LED goes out dark and a flag reports the underrun.

Top module: `ws_lane_encoder`

## Requirements
- R1: One slot lasts CLK_HZ·SLOT_NS/10⁹ clock cycles, which is 4 cycles for the bench build. `lane_out` changes only at slot boundaries, counted from the cycle after `start` is sampled.
- R2: Within each data bit of a supplied LED, the first slot drives all lanes to 1 and the third slot drives all lanes to 0.
- R3: In the middle slot of each bit, each lane carries its LED's colour reordered as green, red, blue, most significant bit first. Each lane's 24-bit input holds red in bits 23:16, green in 15:8 and blue in 7:0, so the 24 bits are sent as input bits 15..8, then 23..16, then 7..0.
- R4: Lane i occupies `col_data[24*i+23 : 24*i]` and is driven on `lane_out[i]`.
- R5: After `start`, `busy` is high for exactly (4 + 72·N + 4) slots. The first 4 slots and the last 4 slots are all-zero on every lane.
- R6: A count of 0 produces only the 8 zero slots. A count above 50 is treated as 50.
- R7: `col_ready` can be high only in two windows: during the leading zero slots, which fetch the first LED's word, and during the last data bit of an LED that has a successor. It is never high while idle.
- R8: If no word has been accepted when an LED begins, all lanes stay 0 for that LED's 72 slots and `underrun` is high for exactly those slots. LEDs before and after it are sent normally.
- R9: A `start` pulse while `busy` is high has no effect. This includes its count, and the transfer length does not change.
- R10: After reset, `lane_out`, `busy`, `col_ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer when idle |
| led_count | input | $clog2(MAX_LEDS+1) | LED positions per lane, sampled with start |
| col_valid | input | 1 | Colour word offered |
| col_ready | output | 1 | Colour word accepted on this edge when valid |
| col_data | input | 24·LANES | One RGB value per lane, lane i at bits 24i+23:24i |
| lane_out | output | LANES | Waveform, bit i drives chain i |
| busy | output | 1 | Transfer in progress |
| underrun | output | 1 | Current LED is being sent dark for lack of data |

## Verification
The bench builds the block with 16 lanes and a clock-rate parameter of 10 MHz. A slot is then four clock cycles, so a transfer at the 50-LED ceiling, including the clamped over-range count, completes within the run time. It checks every cycle against a slot-by-slot model. The model covers the colour reordering on all sixteen lanes, underruns on the first and the last LED, a restart attempted mid-transfer, and randomly sized transfers.

// File: rtl/ws_lane_pkg.sv
package ws_lane_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_DATA, PH_POST} phase_t;

  localparam int BITS_PER_LED  = 24;
  localparam int SLOTS_PER_BIT = 3;

  // clock cycles in one slot of slot_ns nanoseconds
  function automatic int slot_cycles(input longint clk_hz, input longint slot_ns);
    longint c;
    c = (clk_hz * slot_ns) / 64'd1000000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // input packs R[23:16] G[15:8] B[7:0]; wire order is G, R, B
  function automatic logic [23:0] grb_order(input logic [23:0] rgb);
    return {rgb[15:8], rgb[23:16], rgb[7:0]};
  endfunction

  function automatic int frame_slots(input int pre, input int post, input int n);
    return pre + post + n * BITS_PER_LED * SLOTS_PER_BIT;
  endfunction

endpackage

// File: rtl/ws_slot_timer.sv
module ws_slot_timer #(
  parameter int SLOT_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic slot_tick
);
  localparam int TW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [TW-1:0] cnt;

  assign slot_tick = run && (cnt == TW'(SLOT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (slot_tick) cnt <= '0;
    else                cnt <= cnt + TW'(1);
  end

  // R1: a tick never repeats on consecutive cycles when a slot spans several
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (SLOT_CYC > 1 && slot_tick) |=> !slot_tick);
endmodule

// File: rtl/ws_frame_seq.sv
module ws_frame_seq
  import ws_lane_pkg::*;
#(
  parameter int MAX_LEDS   = 50,
  parameter int PRE_SLOTS  = 4,
  parameter int POST_SLOTS = 4,
  parameter int CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] led_count,
  input  logic          slot_tick,
  output phase_t        phase,
  output logic [1:0]    slot_idx,
  output logic [4:0]    bit_idx,
  output logic          load_led,
  output logic          ready_window
);
  localparam int AMAX = (PRE_SLOTS > POST_SLOTS) ? PRE_SLOTS : POST_SLOTS;
  localparam int AW   = $clog2(AMAX + 1);

  logic [CW-1:0] n_q, led_idx;
  logic [AW-1:0] amble;
  logic last_led, pre_done, post_done, bit_last;

  assign last_led  = (led_idx == n_q - CW'(1));
  assign pre_done  = (amble == AW'(PRE_SLOTS - 1));
  assign post_done = (amble == AW'(POST_SLOTS - 1));
  assign bit_last  = (bit_idx == 5'(BITS_PER_LED - 1));

  assign load_led = slot_tick &&
    ((phase == PH_PRE && pre_done && n_q != '0) ||
     (phase == PH_DATA && slot_idx == 2'd2 && bit_last && !last_led));

  assign ready_window = (phase == PH_PRE && n_q != '0) ||
                        (phase == PH_DATA && bit_last && !last_led);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      n_q      <= '0;
      led_idx  <= '0;
      amble    <= '0;
      slot_idx <= '0;
      bit_idx  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_PRE;
          amble <= '0;
          n_q   <= (led_count > CW'(MAX_LEDS)) ? CW'(MAX_LEDS) : led_count;
        end
        PH_PRE: if (slot_tick) begin
          if (pre_done) begin
            amble <= '0;
            if (n_q == '0) phase <= PH_POST;
            else begin
              phase    <= PH_DATA;
              led_idx  <= '0;
              bit_idx  <= '0;
              slot_idx <= '0;
            end
          end else amble <= amble + AW'(1);
        end
        PH_DATA: if (slot_tick) begin
          if (slot_idx == 2'd2) begin
            slot_idx <= '0;
            if (bit_last) begin
              bit_idx <= '0;
              if (last_led) phase <= PH_POST;
              else          led_idx <= led_idx + CW'(1);
            end else bit_idx <= bit_idx + 5'd1;
          end else slot_idx <= slot_idx + 2'd1;
        end
        default: if (slot_tick) begin
          if (post_done) phase <= PH_IDLE;
          else           amble <= amble + AW'(1);
        end
      endcase
    end
  end

  // R5: leaving idle always enters the leading zero slots
  a_r5_enter_pre: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> phase == PH_PRE);
  // R6: the latched count never exceeds the ceiling
  a_r6_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_IDLE |-> n_q <= CW'(MAX_LEDS));
  // R9: a start seen while running leaves the latched count alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start) |=> $stable(n_q));
endmodule

// File: rtl/ws_color_buf.sv
module ws_color_buf
  import ws_lane_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*24-1:0]   col_data,
  input  logic                  col_valid,
  input  logic                  load_led,
  input  logic                  ready_window,
  output logic                  col_ready,
  output logic [LANES*24-1:0]   cur,
  output logic                  blank
);
  logic [LANES*24-1:0] nxt, reord;
  logic nxt_ok, take;

  for (genvar i = 0; i < LANES; i++) begin : g_reord
    assign reord[i*24 +: 24] = grb_order(col_data[i*24 +: 24]);
  end

  assign col_ready = ready_window && !nxt_ok;
  assign take      = col_valid && col_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt    <= '0;
      nxt_ok <= 1'b0;
      cur    <= '0;
      blank  <= 1'b1;
    end else if (load_led) begin
      if (nxt_ok) begin
        cur    <= nxt;
        blank  <= 1'b0;
        nxt_ok <= 1'b0;
      end else if (take) begin
        cur   <= reord;
        blank <= 1'b0;
      end else begin
        blank <= 1'b1;
      end
    end else if (take) begin
      nxt    <= reord;
      nxt_ok <= 1'b1;
    end
  end

  // R8: an LED start with nothing in hand and nothing arriving goes dark
  a_r8_starve_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (load_led && !nxt_ok && !take) |=> blank);
endmodule

// File: rtl/ws_lane_shaper.sv
module ws_lane_shaper
  import ws_lane_pkg::*;
#(
  parameter int LANES = 8
) (
  input  phase_t                phase,
  input  logic [1:0]            slot_idx,
  input  logic [4:0]            bit_idx,
  input  logic [LANES*24-1:0]   cur,
  input  logic                  blank,
  output logic [LANES-1:0]      lane_out,
  output logic                  underrun
);
  logic sending;
  assign sending  = (phase == PH_DATA) && !blank;
  assign underrun = (phase == PH_DATA) && blank;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic data_bit;
    assign data_bit = cur[i*24 + (BITS_PER_LED - 1 - int'(bit_idx))];
    always_comb begin
      if (!sending)               lane_out[i] = 1'b0;
      else if (slot_idx == 2'd0)  lane_out[i] = 1'b1;
      else if (slot_idx == 2'd1)  lane_out[i] = data_bit;
      else                        lane_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ws_lane_encoder.sv
module ws_lane_encoder
  import ws_lane_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int CLK_HZ     = 200_000_000,
  parameter int SLOT_NS    = 400,
  parameter int MAX_LEDS   = 50,
  parameter int PRE_SLOTS  = 4,
  parameter int POST_SLOTS = 4,
  parameter int CW         = $clog2(MAX_LEDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CW-1:0]       led_count,
  input  logic                col_valid,
  output logic                col_ready,
  input  logic [LANES*24-1:0] col_data,
  output logic [LANES-1:0]    lane_out,
  output logic                busy,
  output logic                underrun
);
  localparam int SLOT_CYC = slot_cycles(CLK_HZ, SLOT_NS);

  phase_t phase;
  logic [1:0] slot_idx;
  logic [4:0] bit_idx;
  logic slot_tick, load_led, ready_window, blank;
  logic [LANES*24-1:0] cur;

  assign busy = (phase != PH_IDLE);

  ws_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .slot_tick(slot_tick));

  ws_frame_seq #(.MAX_LEDS(MAX_LEDS), .PRE_SLOTS(PRE_SLOTS),
                 .POST_SLOTS(POST_SLOTS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
    .slot_tick(slot_tick), .phase(phase), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .load_led(load_led), .ready_window(ready_window));

  ws_color_buf #(.LANES(LANES)) u_buf (
    .clk(clk), .rst_n(rst_n), .col_data(col_data), .col_valid(col_valid),
    .load_led(load_led), .ready_window(ready_window), .col_ready(col_ready),
    .cur(cur), .blank(blank));

  ws_lane_shaper #(.LANES(LANES)) u_shape (
    .phase(phase), .slot_idx(slot_idx), .bit_idx(bit_idx), .cur(cur),
    .blank(blank), .lane_out(lane_out), .underrun(underrun));

  // R1: outputs hold between slot boundaries
  a_r1_stable_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_tick) |=> $stable(lane_out));
  // R5: a transfer only begins on a start pulse
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R7: no colour accepted while idle
  a_r7_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    col_ready |-> busy);
  // R8: a starved LED keeps every lane low
  a_r8_underrun_dark: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> lane_out == '0);
endmodule

// File: tb/ws_lane_encoder_tb.sv
`timescale 1ns/1ps
module ws_lane_encoder_tb_top;
  localparam int LANES = 16;
  localparam int SC    = 4;   // 10 MHz parameter, 400 ns slot
  localparam int MAXN  = 50;
  localparam int CW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] led_count = '0;
  logic col_valid = 1'b0;
  logic col_ready;
  logic [LANES*24-1:0] col_data = '0;
  logic [LANES-1:0] lane_out;
  logic busy, underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [LANES*24-1:0] cols [0:MAXN-1];

  always #2.5 clk = ~clk;

  ws_lane_encoder #(.LANES(LANES), .CLK_HZ(10_000_000), .SLOT_NS(400),
                    .MAX_LEDS(MAXN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
    .col_valid(col_valid), .col_ready(col_ready), .col_data(col_data),
    .lane_out(lane_out), .busy(busy), .underrun(underrun));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bit b of the wire sequence for one RGB value: green, red, blue, MSB first
  function automatic logic wire_bit(input logic [23:0] rgb, input int b);
    if (b < 8)       return rgb[15 - b];
    else if (b < 16) return rgb[23 - (b - 8)];
    else             return rgb[7 - (b - 16)];
  endfunction

  task automatic run_frame(input int n_in, input int skip, input int restart_at);
    int n, total, k;
    bit hs;
    string endtag;
    n = (n_in > MAXN) ? MAXN : n_in;
    total = 8 + 72 * n;
    for (int l = 0; l < MAXN; l++)
      for (int i = 0; i < LANES; i++)
        cols[l][i*24 +: 24] = 24'($urandom);
    endtag = (n_in == 0 || n_in > MAXN) ? "R6" : (restart_at >= 0) ? "R9" : "R5";
    @(negedge clk);
    start = 1'b1;
    led_count = CW'(n_in);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    hs = 1'b0;
    for (int j = 0; j <= total * SC; j++) begin
      int t, d, led, b, s;
      logic [LANES-1:0] e;
      bit eu, win;
      string tag;
      if (hs) k++;
      if (skip >= 0 && k == skip && j >= (4 + 72 * skip) * SC) k++;
      col_valid = (k < n) && (k != skip);
      col_data  = (k < n) ? cols[k] : '0;
      if (j == restart_at) begin start = 1'b1; led_count = 6'd7; end
      else start = 1'b0;
      hs = col_valid && col_ready;
      if (j < total * SC) begin
        t = j / SC;
        e = '0; eu = 1'b0; win = 1'b0;
        if (t < 4) begin
          tag = "R5"; win = (n > 0);
        end else if (t >= 4 + 72 * n) begin
          tag = "R5";
        end else begin
          d = t - 4; led = d / 72; b = (d % 72) / 3; s = d % 3;
          win = (b == 23) && (led < n - 1);
          if (led == skip) begin
            tag = "R8"; eu = 1'b1;
          end else if (s == 0) begin
            tag = "R2"; e = '1;
          end else if (s == 2) begin
            tag = "R2";
          end else begin
            tag = "R3 R4";
            for (int i = 0; i < LANES; i++) e[i] = wire_bit(cols[led][i*24 +: 24], b);
          end
        end
        if (j % SC == 0) tag = {"R1 ", tag};
        chk(lane_out == e, tag, 64'(lane_out), 64'(e));
        chk(underrun == eu, "R8 underrun", 64'(underrun), 64'(eu));
        if (!win) chk(col_ready == 1'b0, "R7 ready window", 64'(col_ready), 64'd0);
        if (j == 0 || j == total * SC - 1) chk(busy == 1'b1, endtag, 64'(busy), 64'd1);
      end else begin
        chk(busy == 1'b0, endtag, 64'(busy), 64'd0);
        chk(lane_out == '0, endtag, 64'(lane_out), 64'd0);
      end
      @(negedge clk);
    end
    col_valid = 1'b0;
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(lane_out == '0, "R10 lanes", 64'(lane_out), 64'd0);
    chk(busy == 1'b0, "R10 busy", 64'(busy), 64'd0);
    chk(col_ready == 1'b0, "R10 ready", 64'(col_ready), 64'd0);
    chk(underrun == 1'b0, "R10 underrun", 64'(underrun), 64'd0);
    rst_n = 1'b1;
    // R7: words offered while idle are not taken
    col_valid = 1'b1;
    col_data = '1;
    repeat (5) begin
      @(negedge clk);
      chk(col_ready == 1'b0, "R7 idle", 64'(col_ready), 64'd0);
    end
    col_valid = 1'b0;
    run_frame(1, -1, -1);
    run_frame(3, -1, -1);
    run_frame(0, -1, -1);        // R6 empty transfer
    run_frame(60, -1, -1);       // R6 clamp to 50
    run_frame(5, 0, -1);         // R8 first LED starved
    run_frame(5, 4, -1);         // R8 last LED starved
    run_frame(6, 2, 100);        // R9 restart ignored, R8 middle
    for (int r = 0; r < 4; r++) begin
      int n, sk;
      n  = 1 + int'($urandom % 8);
      sk = ($urandom % 2 == 0) ? -1 : int'($urandom % n);
      run_frame(n, sk, -1);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule